// File: doc/BRIEF.md
# LCD Scanline and Frame Timing Generator

This block produces the line and frame timing for a handheld-style LCD controller that runs off the system clock. Each line is split into a draw part and a horizontal-blank part. Lines are counted from the top of the frame. After the last visible line the block enters vertical blank. The draw and horizontal-blank split carries on through every vertical-blank line, so the block has four phases: visible draw, visible H-blank, V-blank draw and V-blank H-blank.

The block drives status flags for horizontal and vertical blank, and an `is_vblank` indication. It raises a one-cycle H-blank interrupt pulse on entry to either H-blank phase and a one-cycle V-blank interrupt pulse on entry to vertical blank, each gated by its enable input. It also raises a one-cycle `vblank_start` strobe on entry to vertical blank. Elsewhere in the chip this strobe latches the affine reference points and notifies the DMA engine. The strobe does not depend on either enable.

Each phase is timed by a down-counter. The counter is loaded with the phase length on entry, and the phase ends when the counter reaches zero. Every length and count is a parameter. The defaults are a 1006-cycle draw, a 226-cycle H-blank, 160 visible lines and 68 blank lines.

Top module: `lcd_scan_timing`

## Requirements
- R1: After reset, `phase` is 0 (draw) and `line` is 0. `hblank_flag`, `vblank_flag`, `is_vblank`, `hblank_irq`, `vblank_irq` and `vblank_start` are all low.
- R2: `phase` uses the encoding draw = 0, H-blank = 1, V-blank draw = 2 and V-blank H-blank = 3. Both draw phases last DRAW_CYC cycles (default 1006). Both H-blank phases last HBLANK_CYC cycles (default 226). A line therefore lasts 1232 cycles by default.
- R3: `line` increments by one at the end of every H-blank phase, in both visible and V-blank lines. At the end of the H-blank of line VIS_LINES+VBL_LINES-1 (default 227), `line` returns to 0 and `phase` returns to 0.
- R4: Lines 0 to VIS_LINES-1 alternate between phases 0 and 1. At the end of the H-blank of line VIS_LINES-1, `line` becomes VIS_LINES (default 160), `phase` becomes 2 and `vblank_flag` is set.
- R5: `hblank_flag` is high exactly while `phase` is 1 or 3, including on every V-blank line.
- R6: `hblank_irq` is a one-cycle pulse in the first cycle of each phase 1 or phase 3. It occurs only if `hblank_irq_en` was high at the clock edge that started the phase. Otherwise it stays low.
- R7: `vblank_irq` is a one-cycle pulse in the first cycle of phase 2 on line VIS_LINES. It occurs only if `vblank_irq_en` was high at that clock edge.
- R8: `vblank_start` is a one-cycle pulse in the first cycle of vertical blank, once per frame, whatever the enables are.
- R9: `is_vblank` is high exactly while `phase` is 2 or 3.
- R10: `vblank_flag` is high from entry to line VIS_LINES until the wrap to line 0, where it clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hblank_irq_en | input | 1 | Enable for the H-blank interrupt pulse |
| vblank_irq_en | input | 1 | Enable for the V-blank interrupt pulse |
| phase | output | 2 | Current phase: 0 draw, 1 H-blank, 2 V-blank draw, 3 V-blank H-blank |
| line | output | LINE_W (8) | Current line number |
| hblank_flag | output | 1 | High during either H-blank phase |
| vblank_flag | output | 1 | High during vertical blank |
| is_vblank | output | 1 | High in phases 2 and 3 |
| hblank_irq | output | 1 | One-cycle H-blank interrupt pulse |
| vblank_irq | output | 1 | One-cycle V-blank interrupt pulse |
| vblank_start | output | 1 | One-cycle strobe at the start of vertical blank |

## Verification
The bench works out every output for each cycle from a cycle count taken since reset. It holds both enables high for a whole frame, then low for a whole frame, then toggles them at random. This shows whether H-blank pulses keep firing on V-blank lines. A design with one flat V-blank phase would drop them and leave the H-blank flag low on the last lines of the frame. The corner cases it goes after are the transition from the last visible line into blank, with `line` moving to VIS_LINES and the strobe firing once, and the wrap after the last blank line. An off-by-one wrap would show up there as a stale line number or a vertical-blank flag left set. A second instance with the default lengths confirms the 1006 and 226 cycle phase lengths over two lines, which catches a counter loaded with the length instead of the length minus one.

// File: rtl/lcdt_pkg.sv
package lcdt_pkg;

   typedef enum logic [1:0] {
      PH_DRAW  = 2'd0,
      PH_HBL   = 2'd1,
      PH_VDRAW = 2'd2,
      PH_VHBL  = 2'd3
   } lcdt_phase_e;

endpackage

// File: rtl/lcdt_phase_timer.sv
module lcdt_phase_timer #(
   parameter int DRAW_CYC   = 1006,
   parameter int HBLANK_CYC = 226,
   localparam int MAX_CYC   = (DRAW_CYC > HBLANK_CYC) ? DRAW_CYC : HBLANK_CYC,
   localparam int CW        = $clog2(MAX_CYC)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic next_is_hbl,
   output logic expire
);

   localparam logic [CW-1:0] DRAW_LD = CW'(DRAW_CYC - 1);
   localparam logic [CW-1:0] HBL_LD  = CW'(HBLANK_CYC - 1);
   localparam logic [CW-1:0] MAX_LD  = CW'(MAX_CYC - 1);

   generate
      if (DRAW_CYC < 2) begin : g_bad_draw
         $error("lcdt_phase_timer: DRAW_CYC must be at least 2");
      end
      if (HBLANK_CYC < 2) begin : g_bad_hbl
         $error("lcdt_phase_timer: HBLANK_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= DRAW_LD;
      end else if (cnt_q == '0) begin
         cnt_q <= next_is_hbl ? HBL_LD : DRAW_LD;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = (cnt_q == '0);

   // R2
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= MAX_LD);

   // R2
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(expire) && $past(rst_n)) |-> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcdt_line_ctr.sv
module lcdt_line_ctr #(
   parameter int VIS_LINES = 160,
   parameter int VBL_LINES = 68,
   localparam int TOTAL    = VIS_LINES + VBL_LINES,
   localparam int LW       = $clog2(TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output logic [LW-1:0] line,
   output logic          at_last_vis,
   output logic          at_last_line
);

   localparam logic [LW-1:0] LAST_VIS  = LW'(VIS_LINES - 1);
   localparam logic [LW-1:0] LAST_LINE = LW'(TOTAL - 1);

   logic [LW-1:0] line_q;

   generate
      if (VIS_LINES < 1) begin : g_bad_vis
         $error("lcdt_line_ctr: VIS_LINES must be at least 1");
      end
      if (VBL_LINES < 1) begin : g_bad_vbl
         $error("lcdt_line_ctr: VBL_LINES must be at least 1");
      end

      if (TOTAL == (1 << LW)) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               line_q <= '0;
            end else if (step) begin
               line_q <= line_q + 1'b1;
            end
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               line_q <= '0;
            end else if (step) begin
               if (line_q == LAST_LINE) begin
                  line_q <= '0;
               end else begin
                  line_q <= line_q + 1'b1;
               end
            end
         end
      end
   endgenerate

   assign line         = line_q;
   assign at_last_vis  = (line_q == LAST_VIS);
   assign at_last_line = (line_q == LAST_LINE);

   // R3
   line_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      line_q <= LAST_LINE);

   // R3
   line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(step)) |-> $stable(line_q));

endmodule

// File: rtl/lcdt_event_gen.sv
module lcdt_event_gen (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_hbl,
   input  logic line_end,
   input  logic enter_vbl,
   input  logic frame_end,
   input  logic h_en,
   input  logic v_en,
   output logic hflag,
   output logic vflag,
   output logic hirq,
   output logic virq,
   output logic vstart
);

   logic hflag_q, vflag_q, hirq_q, virq_q, vstart_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hflag_q  <= 1'b0;
         vflag_q  <= 1'b0;
         hirq_q   <= 1'b0;
         virq_q   <= 1'b0;
         vstart_q <= 1'b0;
      end else begin
         hirq_q   <= enter_hbl & h_en;
         virq_q   <= enter_vbl & v_en;
         vstart_q <= enter_vbl;
         if (enter_hbl) begin
            hflag_q <= 1'b1;
         end else if (line_end) begin
            hflag_q <= 1'b0;
         end
         if (enter_vbl) begin
            vflag_q <= 1'b1;
         end else if (frame_end) begin
            vflag_q <= 1'b0;
         end
      end
   end

   assign hflag  = hflag_q;
   assign vflag  = vflag_q;
   assign hirq   = hirq_q;
   assign virq   = virq_q;
   assign vstart = vstart_q;

   // R6
   hirq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hirq_q |-> ($past(h_en) && hflag_q));

   // R7
   virq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      virq_q |-> ($past(v_en) && vstart_q));

   // R8
   vstart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vstart_q |=> !vstart_q);

   // R6
   hirq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hirq_q |=> !hirq_q);

endmodule

// File: rtl/lcd_scan_timing.sv
module lcd_scan_timing #(
   parameter int DRAW_CYC   = 1006,
   parameter int HBLANK_CYC = 226,
   parameter int VIS_LINES  = 160,
   parameter int VBL_LINES  = 68,
   localparam int LINE_W    = $clog2(VIS_LINES + VBL_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hblank_irq_en,
   input  logic              vblank_irq_en,
   output logic [1:0]        phase,
   output logic [LINE_W-1:0] line,
   output logic              hblank_flag,
   output logic              vblank_flag,
   output logic              is_vblank,
   output logic              hblank_irq,
   output logic              vblank_irq,
   output logic              vblank_start
);

   import lcdt_pkg::*;

   lcdt_phase_e phase_q, phase_d;
   logic        expire;
   logic        at_last_vis, at_last_line;
   logic        enter_hbl, line_end, enter_vbl, frame_end;

   // A draw-type phase (bit 0 clear) is always followed by an H-blank.
   lcdt_phase_timer #(
      .DRAW_CYC   (DRAW_CYC),
      .HBLANK_CYC (HBLANK_CYC)
   ) u_timer (
      .clk         (clk),
      .rst_n       (rst_n),
      .next_is_hbl (~phase_q[0]),
      .expire      (expire)
   );

   assign enter_hbl = expire & ~phase_q[0];
   assign line_end  = expire &  phase_q[0];
   assign enter_vbl = line_end & (phase_q == PH_HBL)  & at_last_vis;
   assign frame_end = line_end & (phase_q == PH_VHBL) & at_last_line;

   lcdt_line_ctr #(
      .VIS_LINES (VIS_LINES),
      .VBL_LINES (VBL_LINES)
   ) u_line (
      .clk          (clk),
      .rst_n        (rst_n),
      .step         (line_end),
      .line         (line),
      .at_last_vis  (at_last_vis),
      .at_last_line (at_last_line)
   );

   always_comb begin
      phase_d = phase_q;
      if (expire) begin
         unique case (phase_q)
            PH_DRAW:  phase_d = PH_HBL;
            PH_HBL:   phase_d = at_last_vis  ? PH_VDRAW : PH_DRAW;
            PH_VDRAW: phase_d = PH_VHBL;
            PH_VHBL:  phase_d = at_last_line ? PH_DRAW  : PH_VDRAW;
            default:  phase_d = PH_DRAW;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_DRAW;
      end else begin
         phase_q <= phase_d;
      end
   end

   lcdt_event_gen u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .enter_hbl (enter_hbl),
      .line_end  (line_end),
      .enter_vbl (enter_vbl),
      .frame_end (frame_end),
      .h_en      (hblank_irq_en),
      .v_en      (vblank_irq_en),
      .hflag     (hblank_flag),
      .vflag     (vblank_flag),
      .hirq      (hblank_irq),
      .virq      (vblank_irq),
      .vstart    (vblank_start)
   );

   assign phase     = phase_q;
   assign is_vblank = phase_q[1];

   // R2
   phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$stable(phase_q)) |-> $past(expire));

   // R5
   hflag_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hblank_flag == phase_q[0]);

   // R10
   vflag_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_flag == is_vblank);

   // R4
   vstart_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vblank_start |-> ((phase_q == PH_VDRAW) && (line == LINE_W'(VIS_LINES))));

   // R3
   wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(frame_end)) |-> ((line == '0) && (phase_q == PH_DRAW)));

endmodule

// File: tb/sim_lcd_scan_timing.sv
module sim_lcd_scan_timing;

   localparam int CLK_PERIOD = 10;
   localparam int S_DRAW = 12, S_HBL = 5, S_VIS = 4, S_VBL = 3;
   localparam int S_LINE  = S_DRAW + S_HBL;
   localparam int S_TOTAL = S_VIS + S_VBL;
   localparam int S_FRAME = S_LINE * S_TOTAL;
   localparam int D_DRAW = 1006, D_HBL = 226;
   localparam int D_LINE = D_DRAW + D_HBL;
   localparam int NCYC = 2 * D_LINE + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hen = 1'b0, ven = 1'b0;
   int   checks = 0, errors = 0;

   logic [1:0] ph0, ph1;
   logic [2:0] ln0;
   logic [7:0] ln1;
   logic hf0, vf0, iv0, hi0, vi0, vs0;
   logic hf1, vf1, iv1, hi1, vi1, vs1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   lcd_scan_timing #(.DRAW_CYC(S_DRAW), .HBLANK_CYC(S_HBL),
                     .VIS_LINES(S_VIS), .VBL_LINES(S_VBL)) u0 (
      .clk(clk), .rst_n(rst_n), .hblank_irq_en(hen), .vblank_irq_en(ven),
      .phase(ph0), .line(ln0), .hblank_flag(hf0), .vblank_flag(vf0),
      .is_vblank(iv0), .hblank_irq(hi0), .vblank_irq(vi0), .vblank_start(vs0));

   lcd_scan_timing u1 (
      .clk(clk), .rst_n(rst_n), .hblank_irq_en(hen), .vblank_irq_en(ven),
      .phase(ph1), .line(ln1), .hblank_flag(hf1), .vblank_flag(vf1),
      .is_vblank(iv1), .hblank_irq(hi1), .vblank_irq(vi1), .vblank_start(vs1));

   task automatic chk(input string req, input string what, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic int exp_phase(input int k, input int draw, input int ln_len,
                                    input int vis, input int frame);
      int pos = k % frame;
      int l   = pos / ln_len;
      int off = pos % ln_len;
      return ((l >= vis) ? 2 : 0) + ((off >= draw) ? 1 : 0);
   endfunction

   function automatic int exp_line(input int k, input int ln_len, input int frame);
      return (k % frame) / ln_len;
   endfunction

   task automatic check_small(input int k, input bit he, input bit ve);
      int pos = k % S_FRAME;
      int off = pos % S_LINE;
      int ph  = exp_phase(k, S_DRAW, S_LINE, S_VIS, S_FRAME);
      bit hirq_e = (k > 0) && (off == S_DRAW) && he;
      bit vst_e  = (k > 0) && (pos == S_VIS * S_LINE);
      chk("R2/R4", "phase", int'(ph0), ph);
      chk("R3", "line", int'(ln0), exp_line(k, S_LINE, S_FRAME));
      chk("R5", "hblank_flag", int'(hf0), ph % 2);
      chk("R10", "vblank_flag", int'(vf0), ph / 2);
      chk("R9", "is_vblank", int'(iv0), ph / 2);
      chk("R6", "hblank_irq", int'(hi0), int'(hirq_e));
      chk("R7", "vblank_irq", int'(vi0), int'(vst_e && ve));
      chk("R8", "vblank_start", int'(vs0), int'(vst_e));
   endtask

   initial begin
      void'($urandom(32'h5EED_1CD0));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1", "phase", int'(ph0), 0);
      chk("R1", "line", int'(ln0), 0);
      chk("R1", "flags", int'({hf0, vf0, iv0}), 0);
      chk("R1", "pulses", int'({hi0, vi0, vs0}), 0);
      chk("R1", "default phase", int'(ph1), 0);
      chk("R1", "default line", int'(ln1), 0);
      for (int i = 1; i <= NCYC; i++) begin
         int frame = (i - 1) / S_FRAME;
         if (frame == 0) begin
            hen = 1'b1; ven = 1'b1;
         end else if (frame == 1) begin
            hen = 1'b0; ven = 1'b0;
         end else begin
            hen = 1'($urandom % 2); ven = 1'($urandom % 2);
         end
         @(posedge clk);
         @(negedge clk);
         check_small(i, hen, ven);
         // R2 default lengths: 1006-cycle draw, 226-cycle H-blank
         chk("R2", "default phase", int'(ph1),
             exp_phase(i, D_DRAW, D_LINE, 160, D_LINE * 228));
         chk("R2", "default line", int'(ln1), exp_line(i, D_LINE, D_LINE * 228));
         chk("R6", "default hblank_irq", int'(hi1),
             int'(((i % D_LINE) == D_DRAW) && hen));
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule